// File: doc/BRIEF.md
# Serial Control Register Bank

This block holds the configuration state of a larger device and exposes it to a host through a synchronous serial port. A transfer begins when the host pulls chip select low, and it then moves 16 bits most significant bit first. The first byte is a command code that picks one of eight registers and a direction. The second byte carries the data: the host shifts it in for a write, and the block shifts it out for a read. Seven registers are writable and hold a 7-bit field each, in byte bits 7 to 1. Bit 0 of the byte carries no state. The eighth register is read-only and reports two external status inputs.

The block takes two active-low reset inputs, and they act differently. The initialisation reset clears every field. The system reset leaves the fields alone and acts only as a write permission: two of the registers accept writes only while it is held low. Reads are allowed at any time. All writable fields drive the rest of the chip in parallel, through one flat output bus.

The serial lines are sampled on a local clock that runs at several times the serial rate. Edges of the serial clock are found on that local clock. Input bits are taken on rising serial edges, and read data moves on falling serial edges.

Top module: `sreg_bank`

## Requirements
- R1: While `initRstN` is low, every field on `cfgFlat` reads 0 and `sdo` is 0. The reset acts at once.
- R2: A frame is 8 command bits followed by 8 data bits, most significant bit first, taken on rising `sclk` edges. A write reaches `cfgFlat` only after the 16th rising edge, and no earlier.
- R3: Write code 60h+2·i writes register i, for i from 0 to 6. Data byte bits 7..1 land in `cfgFlat[7i+6:7i]`, with byte bit 7 at the top of the field. Data byte bit 0 is ignored.
- R4: Read code 70h+2·i returns register i on `sdo` during the data byte, most significant bit first. Field bits come in byte bits 7..1 and byte bit 0 is 0. Each bit changes after a falling `sclk` edge, so it is valid at the next rising edge.
- R5: Registers 1, 2, 3, 4 and 6 accept writes whatever the level of `sysRstN`.
- R6: Registers 0 and 5 accept a write only if `sysRstN` is low at the 16th rising edge. Otherwise the register is unchanged.
- R7: Reads return the stored value whatever the level of `sysRstN`.
- R8: Raising or lowering `sysRstN` never changes any stored field.
- R9: Code DCh reads the status register as {`statReq`, `statErr`, six zeros}, sampled at the 8th rising edge. The status register has no write code: code 6Eh changes nothing.
- R10: Any other command code changes no register, and `sdo` stays 0 through its data byte.
- R11: If `csN` rises before the 16th rising edge, no register changes. The next frame is then decoded from its first bit.
- R12: `sdo` is 0 from the first local clock after `csN` goes high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Local clock that samples the serial lines |
| initRstN | input | 1 | Active-low initialisation reset, clears all fields |
| sysRstN | input | 1 | Active-low system reset level, gates writes to registers 0 and 5 |
| csN | input | 1 | Active-low chip select that frames a transfer |
| sclk | input | 1 | Serial clock from the host |
| sdi | input | 1 | Serial data from the host |
| statReq | input | 1 | Status input reported in read bit 7 of code DCh |
| statErr | input | 1 | Status input reported in read bit 6 of code DCh |
| sdo | output | 1 | Serial read data to the host |
| cfgFlat | output | 49 | Fields of registers 0..6, register i at bits 7i+6..7i |

## Verification
A wrong bit counter or command latch shows up within one frame. A write lands early or in the wrong field slice, or a read returns shifted or foreign data on `sdo`. Broken write gating appears on the first write to register 0 or 5 with `sysRstN` high. That write changes `cfgFlat` when it should not. A system-reset toggle that disturbs state shows up on `cfgFlat` at once, with no transfer needed. Aborted frames and unknown codes are each followed by a full transfer, so a stale counter or a leftover command shows up in the next frame.

// File: rtl/sreg_pkg.sv
package sreg_pkg;
  localparam int NUM_REGS   = 8;
  localparam int NUM_WR     = NUM_REGS - 1;
  localparam int FIELD_W    = 7;
  localparam int BYTE_W     = 8;
  localparam int STAT_W     = 2;
  localparam int IDX_W      = $clog2(NUM_REGS);
  localparam int FRAME_BITS = 2 * BYTE_W;
  localparam int CNT_W      = $clog2(FRAME_BITS + 1);
  localparam int FLAT_W     = NUM_WR * FIELD_W;

  localparam logic [CNT_W-1:0] CNT_CMD_LAST = CNT_W'(BYTE_W - 1);
  localparam logic [CNT_W-1:0] CNT_DATA0    = CNT_W'(BYTE_W);
  localparam logic [CNT_W-1:0] CNT_LAST     = CNT_W'(FRAME_BITS - 1);
  localparam logic [CNT_W-1:0] CNT_FULL     = CNT_W'(FRAME_BITS);

  localparam logic [BYTE_W-1:0] WR_BASE   = 8'h60;
  localparam logic [BYTE_W-1:0] RD_BASE   = 8'h70;
  localparam logic [BYTE_W-1:0] STAT_CODE = 8'hDC;
  localparam logic [IDX_W-1:0]  STAT_IDX  = IDX_W'(NUM_REGS - 1);

  // registers that only take writes while the system reset is held low
  localparam logic [NUM_REGS-1:0] LOCK_MASK = 8'b0010_0001;

  typedef enum logic [1:0] {CMD_NONE, CMD_WR, CMD_RD} cmdKind_t;

  typedef struct packed {
    logic             frameIdle;
    logic             shiftIn;
    logic             wrStb;
    logic [IDX_W-1:0] wrIdx;
    logic             rdLoad;
    logic [IDX_W-1:0] rdIdx;
    logic             rdShift;
  } ctlStrobe_t;
endpackage

// File: rtl/sreg_ctl.sv
module sreg_ctl
  import sreg_pkg::*;
(
  input  logic       clk,
  input  logic       initRstN,
  input  logic       sysRstN,
  input  logic       csN,
  input  logic       sclk,
  input  logic       sdi,
  output ctlStrobe_t strb
);
  logic             sclkQ;
  logic [CNT_W-1:0] bitCnt;
  logic [BYTE_W-2:0] cmdSh;
  cmdKind_t         kind;
  logic [IDX_W-1:0] idx;

  logic             sclkRise, sclkFall, inFrame;
  logic [BYTE_W-1:0] cmdNext;
  cmdKind_t         decKind;
  logic [IDX_W-1:0] decIdx;
  logic             dataPhase;

  assign sclkRise  = sclk & ~sclkQ;
  assign sclkFall  = ~sclk & sclkQ;
  assign inFrame   = ~csN;
  assign cmdNext   = {cmdSh, sdi};
  assign dataPhase = (bitCnt >= CNT_DATA0) && (bitCnt <= CNT_LAST);

  // command decode on the byte completed by the current bit
  always_comb begin
    decKind = CMD_NONE;
    decIdx  = '0;
    if (cmdNext == STAT_CODE) begin
      decKind = CMD_RD;
      decIdx  = STAT_IDX;
    end else if (!cmdNext[0] && (int'(cmdNext[IDX_W:1]) < NUM_WR)) begin
      if (cmdNext[BYTE_W-1:IDX_W+1] == WR_BASE[BYTE_W-1:IDX_W+1]) begin
        decKind = CMD_WR;
        decIdx  = cmdNext[IDX_W:1];
      end else if (cmdNext[BYTE_W-1:IDX_W+1] == RD_BASE[BYTE_W-1:IDX_W+1]) begin
        decKind = CMD_RD;
        decIdx  = cmdNext[IDX_W:1];
      end
    end
  end

  always_ff @(posedge clk or negedge initRstN) begin
    if (!initRstN) begin
      sclkQ  <= 1'b1;
      bitCnt <= '0;
      cmdSh  <= '0;
      kind   <= CMD_NONE;
      idx    <= '0;
    end else begin
      sclkQ <= sclk;
      if (csN) begin
        bitCnt <= '0;
        kind   <= CMD_NONE;
      end else if (sclkRise && bitCnt != CNT_FULL) begin
        bitCnt <= bitCnt + 1'b1;
        if (bitCnt < CNT_DATA0) cmdSh <= cmdNext[BYTE_W-2:0];
        if (bitCnt == CNT_CMD_LAST) begin
          kind <= decKind;
          idx  <= decIdx;
        end
      end
    end
  end

  always_comb begin
    strb.frameIdle = csN;
    strb.shiftIn   = inFrame && sclkRise && dataPhase;
    strb.wrStb     = inFrame && sclkRise && (bitCnt == CNT_LAST) && (kind == CMD_WR)
                     && (!LOCK_MASK[idx] || !sysRstN);
    strb.wrIdx     = idx;
    strb.rdLoad    = inFrame && sclkRise && (bitCnt == CNT_CMD_LAST) && (decKind == CMD_RD);
    strb.rdIdx     = decIdx;
    strb.rdShift   = inFrame && sclkFall && dataPhase && (kind == CMD_RD);
  end
endmodule

// File: rtl/sreg_dp.sv
module sreg_dp
  import sreg_pkg::*;
(
  input  logic              clk,
  input  logic              initRstN,
  input  logic              sdi,
  input  logic [STAT_W-1:0] statIn,
  input  ctlStrobe_t        strb,
  output logic              sdo,
  output logic [FLAT_W-1:0] cfgFlat
);
  logic [FIELD_W-1:0] regFile [NUM_WR];
  logic [FIELD_W-1:0] dataSh;
  logic [BYTE_W-1:0]  rdSh;
  logic [FIELD_W-1:0] rdField;
  logic               sdoQ;

  for (genvar g = 0; g < NUM_WR; g++) begin : g_reg
    always_ff @(posedge clk or negedge initRstN) begin
      if (!initRstN) regFile[g] <= '0;
      else if (strb.wrStb && strb.wrIdx == IDX_W'(g)) regFile[g] <= dataSh;
    end
    assign cfgFlat[g*FIELD_W +: FIELD_W] = regFile[g];
  end

  always_comb begin
    rdField = {statIn, {(FIELD_W-STAT_W){1'b0}}};
    for (int k = 0; k < NUM_WR; k++)
      if (strb.rdIdx == IDX_W'(k)) rdField = regFile[k];
  end

  always_ff @(posedge clk or negedge initRstN) begin
    if (!initRstN) begin
      dataSh <= '0;
      rdSh   <= '0;
      sdoQ   <= 1'b0;
    end else begin
      if (strb.shiftIn) dataSh <= {dataSh[FIELD_W-2:0], sdi};
      if (strb.frameIdle) begin
        sdoQ <= 1'b0;
      end else if (strb.rdLoad) begin
        rdSh <= {rdField, 1'b0};
      end else if (strb.rdShift) begin
        sdoQ <= rdSh[BYTE_W-1];
        rdSh <= {rdSh[BYTE_W-2:0], 1'b0};
      end
    end
  end

  assign sdo = sdoQ;
endmodule

// File: rtl/sreg_bank.sv
module sreg_bank
  import sreg_pkg::*;
(
  input  logic              clk,
  input  logic              initRstN,
  input  logic              sysRstN,
  input  logic              csN,
  input  logic              sclk,
  input  logic              sdi,
  input  logic              statReq,
  input  logic              statErr,
  output logic              sdo,
  output logic [FLAT_W-1:0] cfgFlat
);
  ctlStrobe_t ctlS;

  sreg_ctl u_ctl (
    .clk      (clk),
    .initRstN (initRstN),
    .sysRstN  (sysRstN),
    .csN      (csN),
    .sclk     (sclk),
    .sdi      (sdi),
    .strb     (ctlS)
  );

  sreg_dp u_dp (
    .clk      (clk),
    .initRstN (initRstN),
    .sdi      (sdi),
    .statIn   ({statReq, statErr}),
    .strb     (ctlS),
    .sdo      (sdo),
    .cfgFlat  (cfgFlat)
  );
endmodule

// File: rtl/sreg_chk.sv
module sreg_chk
  import sreg_pkg::*;
(
  input logic              clk,
  input logic              initRstN,
  input logic              sysRstN,
  input logic              csN,
  input logic              sdo,
  input logic [FLAT_W-1:0] cfgFlat,
  input ctlStrobe_t        strb
);
  // R3: field outputs move only on the cycle after a write strobe
  a_r3_cfg_moves_on_write: assert property (@(posedge clk) disable iff (!initRstN)
    !strb.wrStb |=> $stable(cfgFlat));

  // R6: a write strobe to a locked register needs system reset low
  a_r6_locked_needs_sysrst: assert property (@(posedge clk) disable iff (!initRstN)
    (strb.wrStb && LOCK_MASK[strb.wrIdx]) |-> !sysRstN);

  // R11: no register activity without chip select
  a_r11_idle_no_ops: assert property (@(posedge clk) disable iff (!initRstN)
    csN |-> (!strb.wrStb && !strb.rdLoad && !strb.rdShift));

  // R12: serial output returns low after deselect
  a_r12_sdo_low_idle: assert property (@(posedge clk) disable iff (!initRstN)
    csN |=> (sdo == 1'b0));

  // R4: at most one shifter operation per cycle
  a_r4_single_op: assert property (@(posedge clk) disable iff (!initRstN)
    $onehot0({strb.wrStb, strb.rdLoad, strb.rdShift}));

  // R9: the status register is never a write target
  a_r9_no_status_write: assert property (@(posedge clk) disable iff (!initRstN)
    strb.wrStb |-> (strb.wrIdx != STAT_IDX));
endmodule

bind sreg_bank sreg_chk u_chk (
  .clk      (clk),
  .initRstN (initRstN),
  .sysRstN  (sysRstN),
  .csN      (csN),
  .sdo      (sdo),
  .cfgFlat  (cfgFlat),
  .strb     (ctlS)
);

// File: tb/sreg_bank_bench.sv
module sreg_bank_bench;
  logic clk = 1'b0;
  logic initRstN = 1'b0, sysRstN = 1'b0, csN = 1'b1, sclk = 1'b1, sdi = 1'b0;
  logic statReq = 1'b0, statErr = 1'b0;
  logic sdo;
  logic [48:0] cfgFlat;

  int total = 0, bad = 0;
  bit finished = 0;
  logic [6:0] model [7];

  always #10 clk = ~clk;

  sreg_bank u_sreg_bank (
    .clk(clk), .initRstN(initRstN), .sysRstN(sysRstN), .csN(csN), .sclk(sclk),
    .sdi(sdi), .statReq(statReq), .statErr(statErr), .sdo(sdo), .cfgFlat(cfgFlat)
  );

  task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] expv);
    total++;
    if (act !== expv) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, expv);
    end
  endtask

  function automatic logic [48:0] flatModel();
    logic [48:0] f;
    for (int i = 0; i < 7; i++) f[i*7 +: 7] = model[i];
    return f;
  endfunction

  task automatic csLow();
    @(negedge clk) csN = 1'b0;
    repeat (2) @(negedge clk);
  endtask

  task automatic csHigh();
    repeat (2) @(negedge clk);
    csN = 1'b1;
    repeat (3) @(negedge clk);
  endtask

  task automatic shiftBit(input logic b, output logic s);
    sclk = 1'b0; sdi = b;
    repeat (2) @(negedge clk);
    s = sdo;
    sclk = 1'b1;
    repeat (2) @(negedge clk);
  endtask

  task automatic xfer(input logic [7:0] cmd, input logic [7:0] dat, input int nBits,
                      output logic [7:0] rd);
    logic s;
    rd = '0;
    csLow();
    for (int k = 0; k < nBits; k++) begin
      shiftBit(k < 8 ? cmd[7-k] : dat[15-k], s);
      if (k >= 8) rd[15-k] = s;
    end
    csHigh();
  endtask

  task automatic wr(input int i, input logic [7:0] dat, input bit takes);
    logic [7:0] rd;
    xfer(8'h60 + 8'(2*i), dat, 16, rd);
    if (takes) model[i] = dat[7:1];
  endtask

  task automatic rdReg(input logic [7:0] code, output logic [7:0] rd);
    xfer(code, 8'h00, 16, rd);
  endtask

  task automatic t_reset();
    chk("R1 fields clear in reset", cfgFlat, 49'h0);
    chk("R1 sdo low in reset", sdo, 1'b0);
    initRstN = 1'b1;
    repeat (3) @(negedge clk);
    chk("R12 sdo low idle", sdo, 1'b0);
  endtask

  task automatic t_write_read();
    logic [7:0] rd;
    sysRstN = 1'b0;
    for (int i = 0; i < 7; i++) begin
      wr(i, {7'(8'h35 * (i + 1) + 8'h11), 1'b1}, 1);
      chk($sformatf("R3 write reg%0d", i), cfgFlat, flatModel());
    end
    for (int i = 0; i < 7; i++) begin
      rdReg(8'h70 + 8'(2*i), rd);
      chk($sformatf("R4 read reg%0d", i), rd, {model[i], 1'b0});
    end
  endtask

  task automatic t_lock();
    sysRstN = 1'b1;
    repeat (2) @(negedge clk);
    wr(0, 8'hAA, 0);
    chk("R6 reg0 locked", cfgFlat, flatModel());
    wr(5, 8'h54, 0);
    chk("R6 reg5 locked", cfgFlat, flatModel());
    for (int i = 1; i < 7; i++) if (i != 5) begin
      wr(i, {7'(8'h5B ^ i), 1'b0}, 1);
      chk($sformatf("R5 reg%0d free write", i), cfgFlat, flatModel());
    end
    sysRstN = 1'b0;
    wr(5, 8'hFE, 1);
    chk("R6 reg5 unlocked", cfgFlat, flatModel());
    wr(0, 8'h02, 1);
    chk("R6 reg0 unlocked", cfgFlat, flatModel());
  endtask

  task automatic t_read_any();
    logic [7:0] rd;
    sysRstN = 1'b1;
    rdReg(8'h7A, rd);
    chk("R7 read reg5 sysRst high", rd, {model[5], 1'b0});
    rdReg(8'h70, rd);
    chk("R7 read reg0 sysRst high", rd, {model[0], 1'b0});
    sysRstN = 1'b0;
    rdReg(8'h76, rd);
    chk("R7 read reg3 sysRst low", rd, {model[3], 1'b0});
  endtask

  task automatic t_sysrst_keep();
    for (int n = 0; n < 4; n++) begin
      @(negedge clk) sysRstN = ~sysRstN;
      repeat (3) @(negedge clk);
      chk("R8 sysRst toggle keeps fields", cfgFlat, flatModel());
    end
    sysRstN = 1'b0;
  endtask

  task automatic t_r2_timing();
    logic s;
    logic [7:0] cmd = 8'h64, dat = 8'h81;
    csLow();
    for (int k = 0; k < 15; k++) shiftBit(k < 8 ? cmd[7-k] : dat[15-k], s);
    repeat (2) @(negedge clk);
    chk("R2 no update before last bit", cfgFlat, flatModel());
    shiftBit(dat[0], s);
    model[2] = dat[7:1];
    chk("R2 update after last bit", cfgFlat, flatModel());
    csHigh();
  endtask

  task automatic t_status();
    logic [7:0] rd;
    statReq = 1'b1; statErr = 1'b0;
    rdReg(8'hDC, rd);
    chk("R9 status req", rd, 8'h80);
    statReq = 1'b0; statErr = 1'b1;
    rdReg(8'hDC, rd);
    chk("R9 status err", rd, 8'h40);
    xfer(8'h6E, 8'hFE, 16, rd);
    chk("R9 no write code for status", cfgFlat, flatModel());
    statErr = 1'b0;
  endtask

  task automatic t_bad_codes();
    logic [7:0] rd;
    logic [7:0] codes [5] = '{8'h61, 8'h7E, 8'h50, 8'hFF, 8'hDD};
    for (int n = 0; n < 5; n++) begin
      xfer(codes[n], 8'hFF, 16, rd);
      chk($sformatf("R10 code %0h no change", codes[n]), cfgFlat, flatModel());
      chk($sformatf("R10 code %0h sdo quiet", codes[n]), rd, 8'h00);
    end
  endtask

  task automatic t_abort();
    logic [7:0] rd;
    xfer(8'h68, 8'h3C, 15, rd);
    chk("R11 short write ignored", cfgFlat, flatModel());
    xfer(8'h62, 8'h11, 5, rd);
    chk("R11 short command ignored", cfgFlat, flatModel());
    wr(4, 8'hC6, 1);
    chk("R11 next frame decodes", cfgFlat, flatModel());
    xfer(8'h78, 8'h00, 10, rd);
    chk("R12 sdo low after aborted read", sdo, 1'b0);
    @(negedge clk) initRstN = 1'b0;
    @(negedge clk);
    for (int i = 0; i < 7; i++) model[i] = '0;
    chk("R1 init reset clears fields", cfgFlat, 49'h0);
    initRstN = 1'b1;
    repeat (2) @(negedge clk);
    rdReg(8'h78, rd);
    chk("R1 read after init reset", rd, 8'h00);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      total++; bad++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    for (int i = 0; i < 7; i++) model[i] = '0;
    repeat (3) @(negedge clk);
    t_reset();
    t_write_read();
    t_lock();
    t_read_any();
    t_sysrst_keep();
    t_r2_timing();
    t_status();
    t_bad_codes();
    t_abort();
    finished = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule